// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns a 64-bit double-format floating-point operand into an integer. The integer can be a 32-bit word or a 64-bit doubleword, and it can be signed or unsigned. A one-cycle start strobe launches a conversion. The operand, the target selects and the rounding choice are captured on that strobe. Four clock edges later the integer result and two flags appear, together with a one-cycle done strobe. The flags are inexact and invalid-conversion. When the conversion is invalid, the result is saturated and the inexact flag stays clear. Exception trapping is handled elsewhere.

Control is a four-state machine, each state lasting one cycle:
- **IDLE** waits. On start it captures the inputs (transition *launch*).
- **ALIGN** splits the operand into sign, class, integer part, guard bit and sticky bit (transition *aligned*).
- **ROUND** adds the rounding increment to the integer magnitude (transition *rounded*).
- **CLAMP** checks the rounded magnitude against the target range, forms the result and flags, and raises done (transition *retire*, back to IDLE).

The range test runs on the rounded value. A value that rounds past the target limit is therefore invalid.

Top module: `fp2int_cvt`

## Requirements
- R1: A start strobe is taken only in IDLE. done_o pulses high for exactly one cycle, visible after the fourth rising edge counted from the edge that samples start. A start seen while busy_o is high has no effect on the running conversion or on its result.
- R2: The rounding mode code is 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. With trunc_i high, code 01 is used whatever rmode_i holds.
- R3: A valid result is the rounded value in two's complement. A doubleword result uses all 64 bits. A word result fills result_o[31:0], and result_o[63:32] is zero.
- R4: For a valid conversion, inexact_o is high exactly when the rounded integer differs from the input value.
- R5: The range check uses the rounded value. When that value lies outside the target range, invalid_o is high and inexact_o is low.
- R6: An out-of-range positive value saturates to the target maximum. An out-of-range negative value saturates to the target minimum. The minimum is -2^(n-1) for a signed target and 0 for an unsigned target.
- R7: For an unsigned target, a negative input that rounds to zero gives result 0 with invalid_o low. inexact_o is high if the input was nonzero. Negative zero raises neither flag.
- R8: A NaN input, quiet or signalling, sets invalid_o. The result is the most negative value for a signed target and 0 for an unsigned target.
- R9: An infinite input is out of range. It sets invalid_o and saturates to the maximum (for +infinity) or the minimum (for -infinity).
- R10: After reset, result_o, inexact_o, invalid_o, done_o and busy_o are zero. result_o and the flags hold their values between done pulses.
- R11: Subnormal inputs are treated as nonzero magnitudes below one and are rounded under the active mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a conversion (taken only in IDLE) |
| operand_i | input | 64 | Packed double-format operand |
| dword_i | input | 1 | 1 = 64-bit target, 0 = 32-bit target |
| unsigned_i | input | 1 | 1 = unsigned target, 0 = signed target |
| trunc_i | input | 1 | 1 = force round toward zero |
| rmode_i | input | 2 | Rounding mode code (see R2) |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 64 | Integer result |
| inexact_o | output | 1 | Inexact flag |
| invalid_o | output | 1 | Invalid-conversion flag |

## Verification
Each operand is applied under all 32 combinations of target width, signedness, truncate select and rounding-mode code.

The operand set is chosen so that each group separates particular behaviours:
- **Ties and near-ties** (±0.5, ±1.5, ±2.5, 0.25, 0.75) separate nearest-even from the other modes, and directed rounding from truncation.
- **Values at each target limit** (2^31-1 plus a half, -2^31 minus a half, 2^32-1 plus a half, the largest doubles below 2^63 and 2^64) show whether the range check is made after rounding. They also show whether saturation picks the right end.
- **Negative fractions against unsigned targets** show the inexact-without-invalid case.
- **NaN, infinity, signed zeros and subnormals** cover the special classes.

A separate sequence sends start while a conversion is running and confirms that the result and the done timing stay unchanged.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;

    // Rounding mode codes; the numeric values are visible at the port.
    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_PINF = 2'b10,
        RM_NINF = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_ROUND = 2'd2,
        ST_CLAMP = 2'd3
    } state_e;

    // Operand classification plus the bits dropped below the binary point.
    typedef struct packed {
        logic sign;
        logic nan;
        logic inf;
        logic huge;
        logic guard;
        logic sticky;
    } opclass_t;

endpackage

// File: rtl/fp2int_align.sv
module fp2int_align
    import fp2int_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64
) (
    input  logic [EXP_W+FRAC_W:0] op_i,
    output opclass_t              cls_o,
    output logic [INT_W-1:0]      ipart_o
);
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int WIN_W = 2 * INT_W;
    localparam int PAD   = INT_W - FRAC_W - 1;
    localparam int SH_W  = $clog2(INT_W) + 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic [EXP_W-1:0]  exp_eff;
    logic              exp_all1;
    logic [FRAC_W:0]   mant;
    logic [WIN_W-1:0]  win;
    logic [WIN_W-1:0]  shifted;
    logic [SH_W-1:0]   shamt;
    int                unb;

    assign exp_f    = op_i[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_f   = op_i[FRAC_W-1:0];
    assign exp_all1 = &exp_f;
    // Subnormals use the minimum exponent with a zero hidden bit.
    assign exp_eff  = (exp_f == '0) ? {{(EXP_W-1){1'b0}}, 1'b1} : exp_f;
    assign mant     = {|exp_f, frac_f};
    // Mantissa LSB sits at weight 2^0 when unb == FRAC_W.
    assign win      = {{PAD{1'b0}}, mant, {INT_W{1'b0}}};

    always_comb begin
        unb     = int'(exp_eff) - BIAS;
        shamt   = '0;
        shifted = win;
        if (unb >= FRAC_W) begin
            shamt   = (unb >= INT_W) ? SH_W'(PAD) : SH_W'(unb - FRAC_W);
            shifted = win << shamt;
        end else begin
            shamt   = (unb <= FRAC_W - INT_W) ? SH_W'(INT_W) : SH_W'(FRAC_W - unb);
            shifted = win >> shamt;
        end
        cls_o.sign   = op_i[EXP_W+FRAC_W];
        cls_o.nan    = exp_all1 && (frac_f != '0);
        cls_o.inf    = exp_all1 && (frac_f == '0);
        cls_o.huge   = !exp_all1 && (unb >= INT_W);
        cls_o.guard  = shifted[INT_W-1];
        cls_o.sticky = |shifted[INT_W-2:0];
    end

    assign ipart_o = shifted[WIN_W-1:INT_W];

endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
    import fp2int_pkg::*;
(
    input  rmode_e mode_i,
    input  logic   sign_i,
    input  logic   lsb_i,
    input  logic   guard_i,
    input  logic   sticky_i,
    output logic   inc_o
);
    logic lost;
    assign lost = guard_i | sticky_i;

    always_comb begin
        unique case (mode_i)
            RM_NEAR: inc_o = guard_i & (sticky_i | lsb_i);
            RM_ZERO: inc_o = 1'b0;
            RM_PINF: inc_o = !sign_i & lost;
            RM_NINF: inc_o = sign_i & lost;
            default: inc_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fp2int_limit.sv
module fp2int_limit
    import fp2int_pkg::*;
#(
    parameter int INT_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic [INT_W:0]   mag_i,
    input  opclass_t         cls_i,
    input  logic             dword_i,
    input  logic             uns_i,
    output logic             invalid_o,
    output logic [INT_W-1:0] result_o
);
    localparam int HI_W = INT_W - WORD_W;
    localparam logic [INT_W:0] ONE       = {{INT_W{1'b0}}, 1'b1};
    localparam logic [INT_W:0] S_MAX_D   = (ONE << (INT_W - 1)) - ONE;
    localparam logic [INT_W:0] S_NEG_D   = ONE << (INT_W - 1);
    localparam logic [INT_W:0] U_MAX_D   = (ONE << INT_W) - ONE;
    localparam logic [INT_W:0] S_MAX_W   = (ONE << (WORD_W - 1)) - ONE;
    localparam logic [INT_W:0] S_NEG_W   = ONE << (WORD_W - 1);
    localparam logic [INT_W:0] U_MAX_W   = (ONE << WORD_W) - ONE;

    logic [INT_W:0]   pos_lim;
    logic [INT_W:0]   neg_lim;
    logic             range_bad;
    logic [INT_W-1:0] min_val;
    logic [INT_W-1:0] max_val;
    logic [INT_W-1:0] twos;

    always_comb begin
        if (uns_i) begin
            pos_lim = dword_i ? U_MAX_D : U_MAX_W;
            neg_lim = '0;
            min_val = '0;
            max_val = dword_i ? U_MAX_D[INT_W-1:0] : U_MAX_W[INT_W-1:0];
        end else begin
            pos_lim = dword_i ? S_MAX_D : S_MAX_W;
            neg_lim = dword_i ? S_NEG_D : S_NEG_W;
            min_val = dword_i ? S_NEG_D[INT_W-1:0] : S_NEG_W[INT_W-1:0];
            max_val = dword_i ? S_MAX_D[INT_W-1:0] : S_MAX_W[INT_W-1:0];
        end
        range_bad = cls_i.sign ? (mag_i > neg_lim) : (mag_i > pos_lim);
        invalid_o = cls_i.nan | cls_i.inf | cls_i.huge | range_bad;
        twos      = cls_i.sign ? (~mag_i[INT_W-1:0] + 1'b1) : mag_i[INT_W-1:0];
        if (cls_i.nan)
            result_o = min_val;
        else if (invalid_o)
            result_o = cls_i.sign ? min_val : max_val;
        else if (dword_i)
            result_o = twos;
        else
            result_o = {{HI_W{1'b0}}, twos[WORD_W-1:0]};
    end

endmodule

// File: rtl/fp2int_cvt.sv
module fp2int_cvt
    import fp2int_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [EXP_W+FRAC_W:0]  operand_i,
    input  logic                   dword_i,
    input  logic                   unsigned_i,
    input  logic                   trunc_i,
    input  logic [1:0]             rmode_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [INT_W-1:0]       result_o,
    output logic                   inexact_o,
    output logic                   invalid_o
);
    localparam int OP_W = EXP_W + FRAC_W + 1;

    state_e           state_q, state_d;
    logic [OP_W-1:0]  op_q;
    logic             dword_q, uns_q;
    rmode_e           mode_q;
    opclass_t         cls_c, cls_q;
    logic [INT_W-1:0] ipart_c, ipart_q;
    logic [INT_W:0]   mag_q;
    logic             inc_c;
    logic             inv_c;
    logic [INT_W-1:0] res_c;

    fp2int_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
        .op_i    (op_q),
        .cls_o   (cls_c),
        .ipart_o (ipart_c)
    );

    fp2int_round u_round (
        .mode_i   (mode_q),
        .sign_i   (cls_q.sign),
        .lsb_i    (ipart_q[0]),
        .guard_i  (cls_q.guard),
        .sticky_i (cls_q.sticky),
        .inc_o    (inc_c)
    );

    fp2int_limit #(.INT_W(INT_W), .WORD_W(WORD_W)) u_limit (
        .mag_i     (mag_q),
        .cls_i     (cls_q),
        .dword_i   (dword_q),
        .uns_i     (uns_q),
        .invalid_o (inv_c),
        .result_o  (res_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ALIGN;
            ST_ALIGN: state_d = ST_ROUND;
            ST_ROUND: state_d = ST_CLAMP;
            ST_CLAMP: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= '0;
            dword_q   <= 1'b0;
            uns_q     <= 1'b0;
            mode_q    <= RM_NEAR;
            cls_q     <= '0;
            ipart_q   <= '0;
            mag_q     <= '0;
            result_o  <= '0;
            inexact_o <= 1'b0;
            invalid_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    op_q    <= operand_i;
                    dword_q <= dword_i;
                    uns_q   <= unsigned_i;
                    mode_q  <= trunc_i ? RM_ZERO : rmode_e'(rmode_i);
                end
                ST_ALIGN: begin
                    cls_q   <= cls_c;
                    ipart_q <= ipart_c;
                end
                ST_ROUND: mag_q <= {1'b0, ipart_q} + {{INT_W{1'b0}}, inc_c};
                ST_CLAMP: begin
                    result_o  <= res_c;
                    invalid_o <= inv_c;
                    inexact_o <= !inv_c && (cls_q.guard || cls_q.sticky);
                    done_o    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(inexact_o && invalid_o));

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (state_q != ST_ALIGN));

    // R3
    word_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dword_q) |-> (result_o[INT_W-1:WORD_W] == '0));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(invalid_o) && $stable(inexact_o)));

endmodule

// File: tb/fp2int_cvt_tb.sv
module fp2int_cvt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] operand_i = '0;
    logic        dword_i = 1'b0, unsigned_i = 1'b0, trunc_i = 1'b0;
    logic [1:0]  rmode_i = 2'b00;
    logic        busy_o, done_o, inexact_o, invalid_o;
    logic [63:0] result_o;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    localparam int N_OPS = 40;
    localparam real P63 = 9223372036854775808.0;
    localparam real P64 = 18446744073709551616.0;
    localparam real P31 = 2147483648.0;
    localparam real P32 = 4294967296.0;

    fp2int_cvt u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .dword_i(dword_i), .unsigned_i(unsigned_i), .trunc_i(trunc_i),
        .rmode_i(rmode_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .inexact_o(inexact_o), .invalid_o(invalid_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, got %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    function automatic logic [63:0] op_bits(input int k);
        case (k)
            0:  return $realtobits(0.0);
            1:  return 64'h8000_0000_0000_0000;          // -0.0
            2:  return $realtobits(0.5);
            3:  return $realtobits(1.5);
            4:  return $realtobits(2.5);
            5:  return $realtobits(-0.5);
            6:  return $realtobits(-1.5);
            7:  return $realtobits(-2.5);
            8:  return $realtobits(0.25);
            9:  return $realtobits(0.75);
            10: return $realtobits(-0.75);
            11: return 64'h0000_0000_0000_0001;          // min subnormal
            12: return 64'h800F_FFFF_FFFF_FFFF;          // negative subnormal
            13: return $realtobits(2147483647.0);
            14: return $realtobits(2147483647.5);
            15: return $realtobits(2147483646.5);
            16: return $realtobits(2147483648.0);
            17: return $realtobits(-2147483648.0);
            18: return $realtobits(-2147483648.5);
            19: return $realtobits(-2147483649.0);
            20: return $realtobits(4294967295.0);
            21: return $realtobits(4294967295.5);
            22: return $realtobits(4294967296.0);
            23: return $realtobits(P63);
            24: return $realtobits(9223372036854774784.0);
            25: return $realtobits(-P63);
            26: return $realtobits(P64);
            27: return $realtobits(18446744073709549568.0);
            28: return 64'h7FF0_0000_0000_0000;          // +inf
            29: return 64'hFFF0_0000_0000_0000;          // -inf
            30: return 64'h7FF8_0000_0000_0000;          // quiet NaN
            31: return 64'h7FF0_0000_0000_0001;          // signalling NaN
            32: return 64'hFFF8_0000_0000_0000;          // negative NaN
            33: return $realtobits(123456789.75);
            34: return $realtobits(-987654321.125);
            35: return $realtobits(1.0e30);
            36: return $realtobits(-1.0e30);
            37: return $realtobits(3.0);
            38: return $realtobits(4503599627370495.5);
            39: return $realtobits(-9223372036854774784.0);
            default: return '0;
        endcase
    endfunction

    task automatic model(input logic [63:0] b, input logic dw, input logic un,
                         input logic tr, input logic [1:0] rm,
                         output logic [63:0] er, output logic ei, output logic ev);
        real x, fl, ce, r, lo, hi, d;
        logic [1:0] m;
        logic is_nan, is_inf;
        logic [63:0] mn, mx;
        x  = $bitstoreal(b);
        is_nan = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
        is_inf = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
        m  = tr ? 2'b01 : rm;                                  // R2
        fl = $floor(x);
        ce = $ceil(x);
        if (is_inf) r = x;
        else begin
            case (m)
                2'b00: begin
                    d = x - fl;
                    if (d < 0.5) r = fl;
                    else if (d > 0.5) r = fl + 1.0;
                    else r = (fl / 2.0 == $floor(fl / 2.0)) ? fl : fl + 1.0;
                end
                2'b01: r = (x >= 0.0) ? fl : ce;
                2'b10: r = ce;
                default: r = fl;
            endcase
        end
        if (un) begin lo = 0.0; hi = dw ? P64 : P32; mn = '0;
                      mx = dw ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF; end
        else    begin lo = dw ? -P63 : -P31; hi = dw ? P63 : P31;
                      mn = dw ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
                      mx = dw ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF; end
        ei = 1'b0;
        if (is_nan) begin ev = 1'b1; er = mn; end                // R8
        else if (r < lo) begin ev = 1'b1; er = mn; end           // R6
        else if (r >= hi) begin ev = 1'b1; er = mx; end          // R6
        else begin
            ev = 1'b0;
            ei = (r != x);                                       // R4
            if (r >= P63) er = 64'(longint'(r - P63)) ^ 64'h8000_0000_0000_0000;
            else          er = 64'(longint'(r));
            if (!dw) er = {32'h0, er[31:0]};                     // R3
        end
    endtask

    task automatic launch(input logic [63:0] b, input logic dw, input logic un,
                          input logic tr, input logic [1:0] rm, output int lat);
        @(negedge clk);
        operand_i = b; dword_i = dw; unsigned_i = un; trunc_i = tr; rmode_i = rm;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 20) begin
            @(posedge clk); #1;
            lat++;
        end
    endtask

    task automatic compare(input string tag, input logic [63:0] b, input logic dw,
                           input logic un, input logic tr, input logic [1:0] rm,
                           input logic [63:0] er, input logic ei, input logic ev);
        n_vec++;
        if (result_o !== er || inexact_o !== ei || invalid_o !== ev) begin
            n_bad++;
            $display("FAIL %s op=%h dw=%0b un=%0b tr=%0b rm=%0d got res=%h ix=%0b iv=%0b exp res=%h ix=%0b iv=%0b",
                     tag, b, dw, un, tr, rm, result_o, inexact_o, invalid_o, er, ei, ev);
        end
    endtask

    initial begin
        logic [63:0] er, b, held;
        logic ei, ev;
        int lat;
        string tag;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        n_vec++;
        if (result_o !== 64'h0 || inexact_o !== 1'b0 || invalid_o !== 1'b0 ||
            done_o !== 1'b0 || busy_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: got res=%h ix=%0b iv=%0b done=%0b busy=%0b expected all zero",
                     result_o, inexact_o, invalid_o, done_o, busy_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep: every operand under all 32 control combinations.
        for (int k = 0; k < N_OPS; k++) begin
            for (int c = 0; c < 32; c++) begin
                b = op_bits(k);
                launch(b, c[0], c[1], c[2], c[4:3], lat);
                model(b, c[0], c[1], c[2], c[4:3], er, ei, ev);
                if (b[62:52] == 11'h7FF && b[51:0] != 0) tag = "R8";
                else if (b[62:52] == 11'h7FF)            tag = "R9";
                else if (ev)                             tag = "R5 R6";
                else if (c[1] && b[63])                  tag = "R7";
                else if (b[62:52] == 11'h000)            tag = "R11";
                else if (ei)                             tag = "R4";
                else if (c[2])                           tag = "R2";
                else                                     tag = "R3";
                if (k == 0 && c == 0) begin
                    // R1: done latency of four edges
                    n_vec++;
                    if (lat != 4) begin
                        n_bad++;
                        $display("FAIL R1 latency: got %0d expected 4", lat);
                    end
                end
                compare(tag, b, c[0], c[1], c[2], c[4:3], er, ei, ev);
            end
        end

        // R10: outputs hold and done stays low after a completed conversion.
        held = result_o;
        repeat (4) @(posedge clk);
        #1;
        n_vec++;
        if (result_o !== held || done_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 hold: got res=%h done=%0b expected res=%h done=0",
                     result_o, done_o, held);
        end

        // R1: start while busy is ignored.
        @(negedge clk);
        operand_i = $realtobits(-2.5); dword_i = 1'b0; unsigned_i = 1'b0;
        trunc_i = 1'b0; rmode_i = 2'b00; start_i = 1'b1;
        @(negedge clk);
        operand_i = $realtobits(7.75); dword_i = 1'b1; unsigned_i = 1'b1;
        rmode_i = 2'b10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 2;
        while (!done_o && lat < 20) begin @(posedge clk); #1; lat++; end
        n_vec++;
        if (lat != 4 || result_o !== 64'h0000_0000_FFFF_FFFE || invalid_o !== 1'b0 || inexact_o !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 busy start: got lat=%0d res=%h ix=%0b iv=%0b expected lat=4 res=00000000fffffffe ix=1 iv=0",
                     lat, result_o, inexact_o, invalid_o);
        end
        repeat (6) @(posedge clk);
        #1;
        n_vec++;
        if (done_o !== 1'b0 || busy_o !== 1'b0 || result_o !== 64'h0000_0000_FFFF_FFFE) begin
            n_bad++;
            $display("FAIL R1 no second run: got done=%0b busy=%0b res=%h expected done=0 busy=0 res=00000000fffffffe",
                     done_o, busy_o, result_o);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule